// File: doc/BRIEF.md
# DMA Channel Register and Status Unit

This block holds the software-visible state of a seven-channel DMA controller. Each channel has a control word, a 16-bit transfer count, a peripheral base address and a memory base address, all reached over a word-wide register bus with separate read and write strobes. The data-moving engine and the channel arbiter sit elsewhere. They read the stored values, and they report back to this block through three one-cycle event pulses per channel: transfer done, half done and bus error.

The events are latched into a shared status word, four flags per channel, whether or not the matching interrupt enable is set. Software clears the flags by writing ones to a shared clear word. Each channel has its own interrupt output. A bus error also switches off its channel. The count and address registers are locked while a channel is enabled. Addresses are trimmed to the alignment of the configured access size when they are written.

Register map (word addresses): channel n uses the five words from 5n upward. The offsets are 0 control, 1 count, 2 peripheral address, 3 memory address and 4 priority. The status word is at 5·N_CH and the clear word is at 5·N_CH+1. With the default of seven channels these are 35 and 36.

Top module: `dma_chan_regs`

## Requirements
- R1: The control word holds the following fields. Bit 0 is the enable. Bit 1 is the done interrupt enable, bit 2 the half-done interrupt enable and bit 3 the error interrupt enable. Bits 9:8 hold the peripheral size and bits 11:10 the memory size, each coded 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. Bits 13:12 hold the priority. All other bits read as zero.
- R2: A write to the priority word changes only control bits 13:12, taking them from write-data bits 1:0. The priority word reads back the priority in bits 1:0.
- R3: Writes to the count, peripheral-address and memory-address words are ignored while the channel's enable bit is set. The count keeps write-data bits 15:0 only.
- R4: An address register written while its size field is 1 stores the value with bit 0 cleared. With a size field of 2 or 3 it stores the value with bits 1:0 cleared. With a size field of 0 it stores the value unchanged.
- R5: A done, half or error event pulse sets, one cycle later, the channel's matching flag (bit 1, 2 or 3 of its group) and its global flag (bit 0 of its group). This happens even when the interrupt enables are clear.
- R6: Writing a 1 to a bit of the clear word clears the matching status flag. A 1 in a channel's global-clear bit (bit 4n) clears all four flags of that channel. Flags that receive no clear stay set.
- R7: A flag whose event arrives in the same cycle as its clear stays set.
- R8: An error event clears the channel's enable bit one cycle later, even if the same cycle writes a 1 to that enable bit.
- R9: The interrupt output of a channel is high exactly when its global flag is set and at least one of the done, half or error flags is set with its matching enable.
- R10: Channel n's flags sit at bits 4n+3:4n of the status word. The clear word reads as zero. Writes to the status word are ignored.
- R11: After reset, every register and flag is zero and every interrupt output is low. Read data is returned one cycle after the read strobe and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| done_i | input | 7 | Per-channel transfer-done pulse |
| half_i | input | 7 | Per-channel half-done pulse |
| err_i | input | 7 | Per-channel bus-error pulse |
| irq_o | output | 7 | Per-channel interrupt |

## Verification
A stale or wrong flag shows up on irq_o in the cycle after the event or clear that should have changed it. It also appears in the status word on the first read that follows. A lock that fails or an enable bit that error handling does not clear can only be seen by reading back the channel's words. For that reason, every protected write and every error is followed at once by a read of the affected register. Alignment faults appear in the low address bits on the next read of the address word.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned WIN = 5;

  localparam int unsigned OFS_CTL  = 0;
  localparam int unsigned OFS_CNT  = 1;
  localparam int unsigned OFS_PADR = 2;
  localparam int unsigned OFS_MADR = 3;
  localparam int unsigned OFS_PRIO = 4;

  typedef struct packed {
    logic [1:0] prio;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       err_ie;
    logic       half_ie;
    logic       done_ie;
    logic       en;
  } chan_cfg_t;

  function automatic logic [DW-1:0] pack_cfg(input chan_cfg_t c);
    logic [DW-1:0] w;
    w        = '0;
    w[0]     = c.en;
    w[1]     = c.done_ie;
    w[2]     = c.half_ie;
    w[3]     = c.err_ie;
    w[9:8]   = c.psize;
    w[11:10] = c.msize;
    w[13:12] = c.prio;
    return w;
  endfunction

  function automatic chan_cfg_t unpack_cfg(input logic [DW-1:0] w);
    chan_cfg_t c;
    c.en      = w[0];
    c.done_ie = w[1];
    c.half_ie = w[2];
    c.err_ie  = w[3];
    c.psize   = w[9:8];
    c.msize   = w[11:10];
    c.prio    = w[13:12];
    return c;
  endfunction

  // size 1 -> halfword, size 2/3 -> word
  function automatic logic [DW-1:0] align_addr(input logic [DW-1:0] a, input logic [1:0] sz);
    logic [DW-1:0] r;
    r = a;
    if (sz[1])          r[1:0] = 2'b00;
    else if (sz == 2'd1) r[0]  = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_cfg_pkg::*;
#(
  parameter int unsigned BASE   = 0,
  parameter int unsigned BUS_AW = 6,
  parameter int unsigned CW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              err_evt_i,
  output chan_cfg_t         cfg_o,
  output logic [CW-1:0]     cnt_o,
  output logic [DW-1:0]     rd_word_o
);
  localparam logic [BUS_AW-1:0] A_CTL  = BUS_AW'(BASE + OFS_CTL);
  localparam logic [BUS_AW-1:0] A_CNT  = BUS_AW'(BASE + OFS_CNT);
  localparam logic [BUS_AW-1:0] A_PADR = BUS_AW'(BASE + OFS_PADR);
  localparam logic [BUS_AW-1:0] A_MADR = BUS_AW'(BASE + OFS_MADR);
  localparam logic [BUS_AW-1:0] A_PRIO = BUS_AW'(BASE + OFS_PRIO);

  chan_cfg_t     cfg_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] padr_q, madr_q;
  logic          unlocked;

  assign unlocked = ~cfg_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      padr_q <= '0;
      madr_q <= '0;
    end else begin
      if (we_i && addr_i == A_CTL)  cfg_q      <= unpack_cfg(wdata_i);
      if (we_i && addr_i == A_PRIO) cfg_q.prio <= wdata_i[1:0];
      if (err_evt_i)                cfg_q.en   <= 1'b0;
      if (we_i && unlocked) begin
        if (addr_i == A_CNT)  cnt_q  <= wdata_i[CW-1:0];
        if (addr_i == A_PADR) padr_q <= align_addr(wdata_i, cfg_q.psize);
        if (addr_i == A_MADR) madr_q <= align_addr(wdata_i, cfg_q.msize);
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    unique case (1'b1)
      addr_i == A_CTL:  rd_word_o = pack_cfg(cfg_q);
      addr_i == A_CNT:  rd_word_o = DW'(cnt_q);
      addr_i == A_PADR: rd_word_o = padr_q;
      addr_i == A_MADR: rd_word_o = madr_q;
      addr_i == A_PRIO: rd_word_o = DW'(cfg_q.prio);
      default:          rd_word_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit #(
  parameter int unsigned N_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [4*N_CH-1:0] clr_mask_i,
  input  logic [N_CH-1:0]   done_i,
  input  logic [N_CH-1:0]   half_i,
  input  logic [N_CH-1:0]   err_i,
  input  logic [N_CH-1:0]   done_ie_i,
  input  logic [N_CH-1:0]   half_ie_i,
  input  logic [N_CH-1:0]   err_ie_i,
  output logic [4*N_CH-1:0] stat_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [4*N_CH-1:0] stat_q;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic [3:0] clr, set, nxt, cur;
    assign cur = stat_q[4*n +: 4];
    assign clr = clr_we_i ? (clr_mask_i[4*n +: 4] | {4{clr_mask_i[4*n]}}) : 4'b0;
    assign set = {err_i[n], half_i[n], done_i[n], err_i[n] | half_i[n] | done_i[n]};
    // set after clear: a coincident event wins
    assign nxt = (cur & ~clr) | set;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[4*n +: 4] <= 4'b0;
      else         stat_q[4*n +: 4] <= nxt;
    end

    assign irq_o[n] = cur[0] & ((cur[1] & done_ie_i[n]) |
                                (cur[2] & half_ie_i[n]) |
                                (cur[3] & err_ie_i[n]));
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/dma_rd_port.sv
module dma_rd_port
  import dma_cfg_pkg::*;
#(
  parameter int unsigned N_CH   = 7,
  parameter int unsigned BUS_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     slot_word_i [N_CH],
  input  logic [4*N_CH-1:0] stat_i,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(N_CH * WIN);

  logic [DW-1:0] word;

  always_comb begin
    word = '0;
    for (int n = 0; n < N_CH; n++) word |= slot_word_i[n];
    if (addr_i == A_STAT) word = DW'(stat_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= word;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_cfg_pkg::*;
#(
  parameter int unsigned N_CH   = 7,
  parameter int unsigned CW     = 16,
  parameter int unsigned BUS_AW = $clog2(N_CH * WIN + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N_CH-1:0]   done_i,
  input  logic [N_CH-1:0]   half_i,
  input  logic [N_CH-1:0]   err_i,
  output logic [N_CH-1:0]   irq_o
);
  localparam logic [BUS_AW-1:0] A_CLR = BUS_AW'(N_CH * WIN + 1);

  chan_cfg_t          cfg   [N_CH];
  logic [DW-1:0]      sword [N_CH];
  logic [N_CH-1:0]    en_vec, done_ie, half_ie, err_ie;
  logic [CW*N_CH-1:0] cnt_flat;
  logic [4*N_CH-1:0]  stat_vec;

  for (genvar n = 0; n < N_CH; n++) begin : g_slot
    dma_chan_slot #(
      .BASE  (n * WIN),
      .BUS_AW(BUS_AW),
      .CW    (CW)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .we_i     (we_i),
      .err_evt_i(err_i[n]),
      .cfg_o    (cfg[n]),
      .cnt_o    (cnt_flat[CW*n +: CW]),
      .rd_word_o(sword[n])
    );
    assign en_vec[n]  = cfg[n].en;
    assign done_ie[n] = cfg[n].done_ie;
    assign half_ie[n] = cfg[n].half_ie;
    assign err_ie[n]  = cfg[n].err_ie;
  end

  dma_flag_unit #(.N_CH(N_CH)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_we_i  (we_i && addr_i == A_CLR),
    .clr_mask_i(wdata_i[4*N_CH-1:0]),
    .done_i    (done_i),
    .half_i    (half_i),
    .err_i     (err_i),
    .done_ie_i (done_ie),
    .half_ie_i (half_ie),
    .err_ie_i  (err_ie),
    .stat_o    (stat_vec),
    .irq_o     (irq_o)
  );

  dma_rd_port #(.N_CH(N_CH), .BUS_AW(BUS_AW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (re_i),
    .addr_i     (addr_i),
    .slot_word_i(sword),
    .stat_i     (stat_vec),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned N_CH   = 7,
  parameter int unsigned CW     = 16,
  parameter int unsigned BUS_AW = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] addr_i,
  input logic              we_i,
  input logic [N_CH-1:0]   done_i,
  input logic [N_CH-1:0]   half_i,
  input logic [N_CH-1:0]   err_i,
  input logic [N_CH-1:0]   irq_o,
  input logic [N_CH-1:0]   en_vec,
  input logic [4*N_CH-1:0] stat_vec,
  input logic [CW*N_CH-1:0] cnt_flat
);
  localparam logic [BUS_AW-1:0] A_CLR = BUS_AW'(N_CH * 5 + 1);

  for (genvar n = 0; n < N_CH; n++) begin : g_chk
    localparam logic [BUS_AW-1:0] A_CNT = BUS_AW'(n * 5 + 1);

    // R5
    done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[n] |=> (stat_vec[4*n+1] && stat_vec[4*n]));

    // R8
    err_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i[n] |=> !en_vec[n]);

    // R9
    irq_needs_global_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> stat_vec[4*n]);

    // R3
    cnt_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_vec[n] && we_i && addr_i == A_CNT) |=> $stable(cnt_flat[CW*n +: CW]));

    // R6
    flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!done_i[n] && !half_i[n] && !err_i[n] && !(we_i && addr_i == A_CLR))
        |=> $stable(stat_vec[4*n +: 4]));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.N_CH(N_CH), .CW(CW), .BUS_AW(BUS_AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .done_i  (done_i),
  .half_i  (half_i),
  .err_i   (err_i),
  .irq_o   (irq_o),
  .en_vec  (en_vec),
  .stat_vec(stat_vec),
  .cnt_flat(cnt_flat)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [6:0]  done_i = '0, half_i = '0, err_i = '0;
  logic [6:0]  irq_o;

  int n_chk = 0, n_fail = 0;

  localparam logic [5:0] A_STAT = 6'd35;
  localparam logic [5:0] A_CLR  = 6'd36;

  always #5 clk_i = ~clk_i;

  dma_chan_regs u0 (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [5:0] a, input logic [31:0] d,
                     input logic re, input logic [6:0] dn, input logic [6:0] hf,
                     input logic [6:0] er);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; re_i = re;
    done_i = dn; half_i = hf; err_i = er;
    @(negedge clk_i);
    we_i = 0; re_i = 0; done_i = '0; half_i = '0; err_i = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, '0, '0, '0);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    cyc(1'b0, a, '0, 1'b1, '0, '0, '0);
    check(req, rdata_o, exp);
  endtask

  task automatic ev(input logic [6:0] dn, input logic [6:0] hf, input logic [6:0] er);
    cyc(1'b0, '0, '0, 1'b0, dn, hf, er);
  endtask

  task automatic t_reset;
    rd_chk("R11 ctl", 6'd0, 32'h0);
    rd_chk("R11 status", A_STAT, 32'h0);
    check("R11 irq", {25'b0, irq_o}, 32'h0);
  endtask

  task automatic t_cfg;
    wr(6'd10, 32'hFFFF_FFFE);
    rd_chk("R1 field mask", 6'd10, 32'h0000_3F0E);
    wr(6'd14, 32'h0000_0001);
    rd_chk("R2 prio in ctl", 6'd10, 32'h0000_1F0E);
    rd_chk("R2 prio word", 6'd14, 32'h1);
  endtask

  task automatic t_lock;
    wr(6'd6, 32'h0001_ABCD);
    rd_chk("R3 count width", 6'd6, 32'h0000_ABCD);
    wr(6'd5, 32'h1);
    wr(6'd6, 32'h1234);
    rd_chk("R3 count locked", 6'd6, 32'h0000_ABCD);
    wr(6'd7, 32'h55);
    rd_chk("R3 padr locked", 6'd7, 32'h0);
    wr(6'd5, 32'h0);
    wr(6'd6, 32'h1234);
    rd_chk("R3 count unlocked", 6'd6, 32'h1234);
  endtask

  task automatic t_align;
    wr(6'd0, 32'h0000_0100);
    wr(6'd2, 32'h0000_1003);
    rd_chk("R4 half align", 6'd2, 32'h1002);
    wr(6'd0, 32'h0000_0800);
    wr(6'd3, 32'h0000_1003);
    rd_chk("R4 word align", 6'd3, 32'h1000);
    wr(6'd2, 32'h0000_1003);
    rd_chk("R4 byte no align", 6'd2, 32'h1003);
    wr(6'd0, 32'h0000_0F00);
    wr(6'd3, 32'h0000_0077);
    rd_chk("R4 size3 word", 6'd3, 32'h74);
    wr(6'd0, 32'h0);
  endtask

  task automatic t_flags;
    ev(7'b000_1000, 7'b0, 7'b0);
    ev(7'b0, 7'b100_0000, 7'b0);
    rd_chk("R5 R10 layout", A_STAT, 32'h0500_3000);
    check("R5 no irq", {25'b0, irq_o}, 32'h0);
    wr(A_CLR, 32'h0000_2000);
    rd_chk("R6 single clear", A_STAT, 32'h0500_1000);
    wr(A_CLR, 32'h0100_0000);
    rd_chk("R6 global clear", A_STAT, 32'h0000_1000);
    wr(A_CLR, 32'h0000_1000);
    rd_chk("R6 last clear", A_STAT, 32'h0);
    rd_chk("R10 clr reads zero", A_CLR, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk("R10 status ro", A_STAT, 32'h0);
  endtask

  task automatic t_collide;
    ev(7'b001_0000, 7'b0, 7'b0);
    cyc(1'b1, A_CLR, 32'h0001_0000, 1'b0, 7'b001_0000, 7'b0, 7'b0);
    rd_chk("R7 event wins", A_STAT, 32'h0003_0000);
    wr(A_CLR, 32'h0FFF_FFFF);
  endtask

  task automatic t_err;
    wr(6'd25, 32'h1);
    rd_chk("R8 enabled", 6'd25, 32'h1);
    ev(7'b0, 7'b0, 7'b010_0000);
    rd_chk("R8 err disables", 6'd25, 32'h0);
    rd_chk("R8 err flags", A_STAT, 32'h0090_0000);
    cyc(1'b1, 6'd25, 32'h1, 1'b0, 7'b0, 7'b0, 7'b010_0000);
    rd_chk("R8 err beats write", 6'd25, 32'h0);
    wr(A_CLR, 32'h0FFF_FFFF);
  endtask

  task automatic t_irq;
    wr(6'd0, 32'h2);
    ev(7'b000_0001, 7'b0, 7'b0);
    check("R9 done irq", {31'b0, irq_o[0]}, 32'h1);
    wr(A_CLR, 32'h2);
    check("R9 global alone", {31'b0, irq_o[0]}, 32'h0);
    wr(A_CLR, 32'h1);
    wr(6'd0, 32'h8);
    ev(7'b0, 7'b000_0001, 7'b0);
    check("R9 half masked", {31'b0, irq_o[0]}, 32'h0);
    ev(7'b0, 7'b0, 7'b000_0001);
    check("R9 err irq", {25'b0, irq_o}, 32'h1);
    wr(A_CLR, 32'h1);
    check("R9 cleared", {31'b0, irq_o[0]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_cfg();
    t_lock();
    t_align();
    t_flags();
    t_collide();
    t_err();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=%h exp=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule